// File: doc/BRIEF.md
# Source-Side Packet Replay Buffer

This block sits between a traffic source and the data network. Every packet the source injects passes straight through to the network. In the same cycle, each flit is copied into a small circular flit store that all outstanding packets share. The copy is kept until a narrow return channel reports the packet's fate. A positive acknowledgement releases the copy. A negative acknowledgement means a router dropped the packet to make way for higher-priority traffic, so the stored copy is sent again, whole and unchanged. No timer is involved: only acknowledgements change what the buffer holds.

Each outstanding packet occupies one slot. The slot records the packet's tag, its length and its start position in the store, together with a state: idle, sent, or waiting to resend. Slots are released out of order as acknowledgements arrive. Flit storage is returned to the pool strictly in allocation order, so the store remains a simple ring. The source sees backpressure whenever the next packet could not be held in full.

Top module: `rtx_src_buffer`

## Requirements
- R1: After reset no flit is offered to the network (`net_valid` low), `ack_err` is low, and a one-flit head with a free slot is accepted (`inj_ready` high).
- R2: An accepted flit appears on `net_data`/`net_head`/`net_tail` in the same cycle, unchanged. `inj_ready` is low whenever `net_ready` is low.
- R3: A positive acknowledgement (`ack_nack`=0) whose tag matches a sent packet frees that slot. A later acknowledgement carrying the same tag is treated as unmatched. Flit storage comes back only from the oldest allocated slot onwards: the oldest freed slot is reclaimed on the edge after its acknowledgement, and each following consecutive freed slot one edge later.
- R4: Only acknowledgements change a slot's held state. A packet that gets no acknowledgement stays stored indefinitely, is never resent on its own, and can still be replayed by a later NACK.
- R5: A head flit is accepted only if its length `inj_len` is no more than the free flit storage, which is DEPTH (default 30) minus the flits held in unreclaimed slots.
- R6: A negative acknowledgement (`ack_nack`=1) on a sent packet replays it from the store. The replayed head is offered on the second clock edge after the edge that samples the NACK, followed by the rest of the flits one per accepted cycle, with head/tail marking identical to the original. Afterwards the packet counts as sent again and can be acknowledged or NACKed again.
- R7: A replay has priority over new injections. While any replay is pending or in progress and no new packet is partway through, `inj_ready` is low. A new packet already partway through is completed before any replay begins, and its flits are never interleaved with replay flits.
- R8: An acknowledgement whose tag matches no sent packet (including one being replayed) changes no slot. It raises `ack_err` for exactly the one cycle after the edge that samples it.
- R9: When several packets await replay, the lowest slot goes first. Slots are allocated in ring order starting at slot 0 after reset.
- R10: At most NUM_ENT (default 8) packets are held. With every slot in use, a head flit is refused even when flit storage is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inj_valid | input | 1 | Source offers a flit |
| inj_ready | output | 1 | Flit accepted this cycle if valid (backpressure when low) |
| inj_data | input | FLIT_W | Flit payload |
| inj_head | input | 1 | First flit of a packet |
| inj_tail | input | 1 | Last flit of a packet |
| inj_tag | input | TAG_W | Packet tag, sampled with the head flit |
| inj_len | input | LEN_W | Packet length in flits, sampled with the head flit |
| net_valid | output | 1 | Flit offered to the network |
| net_ready | input | 1 | Network takes the flit |
| net_data | output | FLIT_W | Outgoing flit payload |
| net_head | output | 1 | Outgoing head marker |
| net_tail | output | 1 | Outgoing tail marker |
| ack_valid | input | 1 | Acknowledgement present |
| ack_tag | input | TAG_W | Tag of the acknowledged packet |
| ack_nack | input | 1 | 0 = delivered, 1 = dropped, replay |
| ack_err | output | 1 | Previous acknowledgement matched no sent packet |

## Verification
Results arrive at different depths. Pass-through flits and backpressure are combinational and are checked one time unit after the inputs change. `ack_err` is registered and is checked at the falling edge after the acknowledgement's rising edge, and again one cycle later to see it drop. A replayed head is checked absent at the first falling edge after the NACK and present at the second. Reclaimed storage is probed after one edge for each slot that must be reclaimed in order. Flit order and content are compared against a log that records every transfer just before each rising edge.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

    // Slot life cycle
    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_SENT   = 2'd1,
        SLOT_RESEND = 2'd2
    } slot_state_e;

    // Modular add inside a ring of 'depth' positions (a, b < depth)
    function automatic int ring_add(input int a, input int b, input int depth);
        int s;
        s = a + b;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/rtx_pick_low.sv
module rtx_pick_low #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rtx_flit_store.sv
module rtx_flit_store #(
    parameter int FLIT_W = 32,
    parameter int DEPTH  = 30,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [FLIT_W-1:0] rd_data
);
    logic [FLIT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rtx_tag_match.sv
module rtx_tag_match #(
    parameter int N  = 8,
    parameter int TW = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]    cand,
    input  logic [N*TW-1:0] tags,
    input  logic [TW-1:0]   key,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = cand[g] && (tags[g*TW +: TW] == key);
    end

    rtx_pick_low #(.N(N), .IW(IW)) u_pick (
        .req (eq),
        .any (hit),
        .idx (idx)
    );
endmodule

// File: rtl/rtx_src_buffer.sv
module rtx_src_buffer
    import rtx_pkg::*;
#(
    parameter int FLIT_W  = 32,
    parameter int DEPTH   = 30,
    parameter int NUM_ENT = 8,
    parameter int TAG_W   = 4,
    parameter int LEN_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inj_valid,
    output logic              inj_ready,
    input  logic [FLIT_W-1:0] inj_data,
    input  logic              inj_head,
    input  logic              inj_tail,
    input  logic [TAG_W-1:0]  inj_tag,
    input  logic [LEN_W-1:0]  inj_len,
    output logic              net_valid,
    input  logic              net_ready,
    output logic [FLIT_W-1:0] net_data,
    output logic              net_head,
    output logic              net_tail,
    input  logic              ack_valid,
    input  logic [TAG_W-1:0]  ack_tag,
    input  logic              ack_nack,
    output logic              ack_err
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int EIDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam int CNT_W  = $clog2(NUM_ENT + 1);
    localparam logic [EIDX_W-1:0] ELAST = EIDX_W'(NUM_ENT - 1);

    typedef struct packed {
        slot_state_e        st;
        logic [TAG_W-1:0]   tag;
        logic [PTR_W-1:0]   start;
        logic [LEN_W-1:0]   len;
    } slot_t;

    slot_t               slots [NUM_ENT];
    logic [PTR_W-1:0]    wr_ptr;
    logic [LEN_W-1:0]    used_q;
    logic [EIDX_W-1:0]   alloc_idx, oldest_idx;
    logic [CNT_W-1:0]    slot_cnt;
    logic                busy_new_q, busy_rty_q;
    logic [EIDX_W-1:0]   rty_idx;
    logic [LEN_W-1:0]    rty_off;
    logic                err_q;

    logic [NUM_ENT-1:0]       sent_vec, resend_vec, vld_map;
    logic [NUM_ENT*TAG_W-1:0] tag_flat;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        assign sent_vec[g]                 = (slots[g].st == SLOT_SENT);
        assign resend_vec[g]               = (slots[g].st == SLOT_RESEND);
        assign vld_map[g]                  = (slots[g].st != SLOT_IDLE);
        assign tag_flat[g*TAG_W +: TAG_W]  = slots[g].tag;
    end

    // Acknowledgement lookup and replay selection
    logic              ack_hit;
    logic [EIDX_W-1:0] ack_idx;
    logic              resend_pend;
    logic [EIDX_W-1:0] resend_idx;

    rtx_tag_match #(.N(NUM_ENT), .TW(TAG_W), .IW(EIDX_W)) u_match (
        .cand (sent_vec),
        .tags (tag_flat),
        .key  (ack_tag),
        .hit  (ack_hit),
        .idx  (ack_idx)
    );

    rtx_pick_low #(.N(NUM_ENT), .IW(EIDX_W)) u_resend (
        .req (resend_vec),
        .any (resend_pend),
        .idx (resend_idx)
    );

    // Capacity and path selection
    logic [LEN_W-1:0] free_flits;
    logic             room, can_start, pass_new, new_fire, alloc;
    logic             rty_start, rty_fire, reclaim;
    logic [LEN_W-1:0] rty_len;
    logic [PTR_W-1:0] rd_addr;
    logic [FLIT_W-1:0] rd_data;

    assign free_flits = LEN_W'(DEPTH) - used_q;
    assign room       = (slot_cnt != CNT_W'(NUM_ENT)) && (inj_len != '0)
                        && (inj_len <= free_flits);
    assign can_start  = !busy_new_q && !busy_rty_q && !resend_pend && room && inj_head;
    assign pass_new   = busy_new_q || can_start;
    assign inj_ready  = pass_new && net_ready;
    assign new_fire   = inj_valid && inj_ready;
    assign alloc      = new_fire && !busy_new_q;

    assign rty_start  = !busy_new_q && !busy_rty_q && resend_pend;
    assign rty_len    = slots[rty_idx].len;
    assign rd_addr    = PTR_W'(ring_add(int'(slots[rty_idx].start), int'(rty_off), DEPTH));
    assign rty_fire   = busy_rty_q && net_ready;
    assign reclaim    = (slot_cnt != '0) && (slots[oldest_idx].st == SLOT_IDLE);

    rtx_flit_store #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (new_fire),
        .wr_addr (wr_ptr),
        .wr_data (inj_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        if (busy_rty_q) begin
            net_valid = 1'b1;
            net_data  = rd_data;
            net_head  = (rty_off == '0);
            net_tail  = (rty_off == rty_len - LEN_W'(1));
        end else begin
            net_valid = pass_new && inj_valid;
            net_data  = inj_data;
            net_head  = inj_head;
            net_tail  = inj_tail;
        end
    end

    logic [LEN_W-1:0] used_nxt;
    assign used_nxt = used_q + LEN_W'(new_fire)
                      - (reclaim ? slots[oldest_idx].len : LEN_W'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) slots[i] <= '{SLOT_IDLE, '0, '0, '0};
            wr_ptr     <= '0;
            used_q     <= '0;
            alloc_idx  <= '0;
            oldest_idx <= '0;
            slot_cnt   <= '0;
            busy_new_q <= 1'b0;
            busy_rty_q <= 1'b0;
            rty_idx    <= '0;
            rty_off    <= '0;
            err_q      <= 1'b0;
        end else begin
            used_q   <= used_nxt;
            slot_cnt <= slot_cnt + CNT_W'(alloc) - CNT_W'(reclaim);
            err_q    <= ack_valid && !ack_hit;

            if (new_fire) begin
                wr_ptr     <= PTR_W'(ring_add(int'(wr_ptr), 1, DEPTH));
                busy_new_q <= !inj_tail;
            end
            if (alloc) begin
                slots[alloc_idx] <= '{SLOT_SENT, inj_tag, wr_ptr, inj_len};
                alloc_idx        <= (alloc_idx == ELAST) ? '0 : alloc_idx + 1'b1;
            end
            if (reclaim)
                oldest_idx <= (oldest_idx == ELAST) ? '0 : oldest_idx + 1'b1;

            if (ack_valid && ack_hit)
                slots[ack_idx].st <= ack_nack ? SLOT_RESEND : SLOT_IDLE;

            if (rty_start) begin
                busy_rty_q <= 1'b1;
                rty_idx    <= resend_idx;
                rty_off    <= '0;
            end else if (rty_fire) begin
                if (net_tail) begin
                    busy_rty_q        <= 1'b0;
                    slots[rty_idx].st <= SLOT_SENT;
                end else begin
                    rty_off <= rty_off + 1'b1;
                end
            end
        end
    end

    assign ack_err = err_q;

endmodule

// File: rtl/rtx_src_buffer_chk.sv
module rtx_src_buffer_chk #(
    parameter int FLIT_W  = 32,
    parameter int DEPTH   = 30,
    parameter int NUM_ENT = 8,
    parameter int LEN_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              inj_ready,
    input logic              net_valid,
    input logic              net_ready,
    input logic [FLIT_W-1:0] net_data,
    input logic              ack_valid,
    input logic              ack_nack,
    input logic              ack_err,
    input logic [LEN_W-1:0]  used_q,
    input logic [NUM_ENT-1:0] vld_map,
    input logic              resend_pend,
    input logic              busy_new_q,
    input logic              busy_rty_q,
    input logic              ack_hit
);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        used_q <= LEN_W'(DEPTH));

    assert_replay_first_R7: assert property (@(posedge clk) disable iff (rst)
        (resend_pend || busy_rty_q) && !busy_new_q |-> !inj_ready);

    assert_bad_ack_flag_R8: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !ack_hit |=> ack_err);

    assert_quiet_err_R8: assert property (@(posedge clk) disable iff (rst)
        !ack_valid |=> !ack_err);

    assert_only_ack_frees_R4: assert property (@(posedge clk) disable iff (rst)
        !(ack_valid && !ack_nack) |=> $countones(vld_map) >= $past($countones(vld_map)));

    assert_replay_hold_R6: assert property (@(posedge clk) disable iff (rst)
        busy_rty_q && !net_ready |=> net_valid && $stable(net_data));
endmodule

bind rtx_src_buffer rtx_src_buffer_chk #(
    .FLIT_W(FLIT_W), .DEPTH(DEPTH), .NUM_ENT(NUM_ENT), .LEN_W(LEN_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .inj_ready   (inj_ready),
    .net_valid   (net_valid),
    .net_ready   (net_ready),
    .net_data    (net_data),
    .ack_valid   (ack_valid),
    .ack_nack    (ack_nack),
    .ack_err     (ack_err),
    .used_q      (used_q),
    .vld_map     (vld_map),
    .resend_pend (resend_pend),
    .busy_new_q  (busy_new_q),
    .busy_rty_q  (busy_rty_q),
    .ack_hit     (ack_hit)
);

// File: tb/tb_rtx_src_buffer.sv
module tb_rtx_src_buffer;
    localparam int FLIT_W = 32;
    localparam int TAG_W  = 4;
    localparam int LEN_W  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inj_valid = 1'b0, inj_head = 1'b0, inj_tail = 1'b0;
    logic [FLIT_W-1:0] inj_data = '0;
    logic [TAG_W-1:0]  inj_tag = '0;
    logic [LEN_W-1:0]  inj_len = '0;
    logic inj_ready;
    logic net_valid, net_head, net_tail;
    logic net_ready = 1'b1;
    logic [FLIT_W-1:0] net_data;
    logic ack_valid = 1'b0, ack_nack = 1'b0;
    logic [TAG_W-1:0] ack_tag = '0;
    logic ack_err;

    always #5 clk = ~clk;

    rtx_src_buffer dut (
        .clk(clk), .rst(rst),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
        .inj_head(inj_head), .inj_tail(inj_tail), .inj_tag(inj_tag), .inj_len(inj_len),
        .net_valid(net_valid), .net_ready(net_ready), .net_data(net_data),
        .net_head(net_head), .net_tail(net_tail),
        .ack_valid(ack_valid), .ack_tag(ack_tag), .ack_nack(ack_nack), .ack_err(ack_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Transfer log, sampled just before each rising edge
    logic [FLIT_W-1:0] log_d [64];
    logic              log_h [64];
    logic              log_t [64];
    int                log_n = 0;

    initial forever begin
        @(negedge clk);
        #4;
        if (!rst && net_valid && net_ready && log_n < 64) begin
            log_d[log_n] = net_data;
            log_h[log_n] = net_head;
            log_t[log_n] = net_tail;
            log_n++;
        end
    end

    function automatic logic [FLIT_W-1:0] pat(input int tag, input int i);
        return (32'(tag) << 16) | 32'(i) | 32'hA000_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1; inj_valid = 0; ack_valid = 0; net_ready = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        log_n = 0;
    endtask

    task automatic probe_head(input int len, input bit exp, input string req);
        @(negedge clk);
        inj_valid = 0; inj_head = 1; inj_len = LEN_W'(len);
        #1;
        chk(inj_ready == exp, req, 32'(inj_ready), 32'(exp));
    endtask

    task automatic send_flits(input int tag, input int len, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            @(negedge clk);
            inj_valid = 1; inj_data = pat(tag, i);
            inj_head = (i == 0); inj_tail = (i == len - 1);
            inj_tag = TAG_W'(tag); inj_len = LEN_W'(len);
            #1;
            chk(inj_ready == 1'b1, "R2 accept", 32'(inj_ready), 1);
            chk(net_valid && net_data == pat(tag, i) && net_head == (i == 0) && net_tail == (i == len - 1),
                "R2 mirror", net_data, pat(tag, i));
            @(posedge clk);
        end
        @(negedge clk);
        inj_valid = 0;
    endtask

    task automatic send_pkt(input int tag, input int len);
        send_flits(tag, len, 0, len);
    endtask

    task automatic send_ack(input int tag, input bit nack);
        @(negedge clk);
        ack_valid = 1; ack_tag = TAG_W'(tag); ack_nack = nack;
        @(posedge clk);
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic chk_log(input int at, input int tag, input int i, input int len, input string req);
        chk(at < log_n && log_d[at] == pat(tag, i) && log_h[at] == (i == 0) && log_t[at] == (i == len - 1),
            req, log_d[at], pat(tag, i));
    endtask

    task automatic t_reset();
        reset_dut();
        probe_head(1, 1'b1, "R1 ready after reset");
        chk(net_valid == 1'b0, "R1 net idle", 32'(net_valid), 0);
        chk(ack_err == 1'b0, "R1 no error", 32'(ack_err), 0);
    endtask

    task automatic t_pass();
        reset_dut();
        send_pkt(1, 3);
        chk(log_n == 3, "R2 log count", log_n, 3);
        for (int i = 0; i < 3; i++) chk_log(i, 1, i, 3, "R2 order");
        @(negedge clk);
        net_ready = 0;
        probe_head(2, 1'b0, "R2 stall");
        @(negedge clk);
        net_ready = 1;
    endtask

    task automatic t_nack();
        reset_dut();
        send_pkt(2, 4);
        send_ack(2, 1'b1);
        chk(net_valid == 1'b0, "R6 not before second edge", 32'(net_valid), 0);
        @(negedge clk);
        chk(net_valid && net_head && net_data == pat(2, 0), "R6 replay head", net_data, pat(2, 0));
        repeat (6) @(negedge clk);
        chk(log_n == 8, "R6 replay count", log_n, 8);
        for (int i = 0; i < 4; i++) chk_log(4 + i, 2, i, 4, "R6 replay data");
        send_ack(2, 1'b1);
        repeat (7) @(negedge clk);
        chk(log_n == 12, "R6 second replay", log_n, 12);
        for (int i = 0; i < 4; i++) chk_log(8 + i, 2, i, 4, "R6 second data");
        send_ack(2, 1'b0);
        chk(ack_err == 1'b0, "R3 ack accepted", 32'(ack_err), 0);
        send_ack(2, 1'b0);
        chk(ack_err == 1'b1, "R3 freed slot no longer matches", 32'(ack_err), 1);
    endtask

    task automatic t_no_timeout();
        reset_dut();
        send_pkt(3, 2);
        repeat (500) @(negedge clk);
        chk(log_n == 2, "R4 no spontaneous resend", log_n, 2);
        send_ack(3, 1'b1);
        repeat (5) @(negedge clk);
        chk(log_n == 4, "R4 still held", log_n, 4);
        chk_log(2, 3, 0, 2, "R4 held data");
        chk_log(3, 3, 1, 2, "R4 held data");
    endtask

    task automatic t_capacity();
        reset_dut();
        send_pkt(1, 8);
        send_pkt(2, 8);
        send_pkt(3, 8);
        probe_head(7, 1'b0, "R5 too long");
        probe_head(6, 1'b1, "R5 exact fit");
        send_pkt(4, 6);
        probe_head(1, 1'b0, "R5 full");
        send_ack(2, 1'b0);
        repeat (3) @(negedge clk);
        probe_head(8, 1'b0, "R3 younger not reclaimed");
        send_ack(1, 1'b0);
        @(posedge clk);
        @(posedge clk);
        probe_head(16, 1'b1, "R3 in-order reclaim");
        probe_head(17, 1'b0, "R3 reclaim amount");
    endtask

    task automatic t_slots();
        reset_dut();
        for (int t = 0; t < 8; t++) send_pkt(t, 1);
        probe_head(1, 1'b0, "R10 slots exhausted");
        send_ack(0, 1'b0);
        @(posedge clk);
        probe_head(1, 1'b1, "R10 slot returned");
    endtask

    task automatic t_bad_ack();
        reset_dut();
        send_pkt(5, 1);
        send_ack(9, 1'b0);
        chk(ack_err == 1'b1, "R8 error raised", 32'(ack_err), 1);
        @(negedge clk);
        chk(ack_err == 1'b0, "R8 error one cycle", 32'(ack_err), 0);
        send_ack(5, 1'b1);
        chk(ack_err == 1'b0, "R8 matched nack", 32'(ack_err), 0);
        repeat (4) @(negedge clk);
        chk(log_n == 2, "R8 state untouched by bad tag", log_n, 2);
        send_ack(5, 1'b0);
        send_ack(5, 1'b1);
        chk(ack_err == 1'b1, "R8 nack after free", 32'(ack_err), 1);
        repeat (4) @(negedge clk);
        chk(log_n == 2, "R8 no replay after free", log_n, 2);
    endtask

    task automatic t_priority();
        reset_dut();
        send_pkt(1, 2);
        send_pkt(2, 3);
        send_flits(3, 2, 0, 1);
        send_ack(2, 1'b1);
        send_ack(1, 1'b1);
        chk(net_valid == 1'b0, "R7 no interleave", 32'(net_valid), 0);
        send_flits(3, 2, 1, 2);
        #1;
        inj_head = 1; inj_len = 1;
        #1;
        chk(inj_ready == 1'b0, "R7 new blocked by pending replay", 32'(inj_ready), 0);
        repeat (8) @(negedge clk);
        chk(log_n == 12, "R9 total", log_n, 12);
        chk_log(5, 3, 0, 2, "R7 partial packet finished");
        chk_log(6, 3, 1, 2, "R7 partial packet finished");
        for (int i = 0; i < 2; i++) chk_log(7 + i, 1, i, 2, "R9 lowest slot first");
        for (int i = 0; i < 3; i++) chk_log(9 + i, 2, i, 3, "R9 then next slot");
    endtask

    initial begin
        t_reset();
        t_pass();
        t_nack();
        t_no_timeout();
        t_capacity();
        t_slots();
        t_bad_ack();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule